// File: doc/BRIEF.md
# ADC Result Register with Read Lock

This block stores a 10-bit conversion result and shows it on a byte-wide read bus as a high byte and a low byte. A converter pulses a completion strobe with the new value. Software reads the two bytes one after the other. Each byte has its own read strobe, so the block can tell which byte is being read. Both bytes are read-only. They come out of reset as zero, and the block has no write path.

A read of the low byte locks the stored value until the high byte is read. A 16-bit result therefore comes across an 8-bit bus as one consistent pair. If results arrive while the value is locked, the newest one is kept in a one-deep pending slot and is committed when the lock is released. An alignment-select input chooses right- or left-justified packing of the bytes. Alignment is applied on the output side, so changing the select repacks the stored value without a new conversion.

Top module: `adc_result_reg`

## Requirements
- R1: After reset both output bytes read 0x00.
- R2: With `align_left_i` = 0, `data_hi_o[1:0]` carries result bits 9:8 and `data_hi_o[7:2]` is zero. `data_lo_o` carries result bits 7:0.
- R3: With `align_left_i` = 1, `data_hi_o` carries result bits 9:2. `data_lo_o[7:6]` carries result bits 1:0 and `data_lo_o[5:0]` is zero.
- R4: When the value is unlocked, a `conv_done_i` pulse makes its `conv_data_i` visible on both bytes from the following cycle.
- R5: A `rd_lo_i` pulse locks the value. While it is locked, conversion pulses change neither byte.
- R6: A `rd_hi_i` pulse releases the lock. A high-byte read with no preceding low-byte read leaves the value unlocked, so the next conversion is visible.
- R7: A result that completes while the value is locked is held as pending. It becomes visible in the cycle after the releasing `rd_hi_i`. A later pending result replaces an earlier one.
- R8: Changing `align_left_i` repacks the stored value on the outputs in the same cycle, with no new conversion.
- R9: If `rd_lo_i` and `conv_done_i` occur in the same cycle, the low byte in that cycle shows the old value. The new result becomes pending, and the value stays locked.
- R10: If `rd_hi_i` and `conv_done_i` occur in the same locked cycle, that cycle shows the old value. The new result is committed next and replaces any pending one. If `rd_lo_i` and `rd_hi_i` occur together, the value is left unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | Conversion-complete strobe |
| conv_data_i | input | 10 | Conversion result |
| align_left_i | input | 1 | 1 = left-justified packing, 0 = right-justified packing |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| data_lo_o | output | 8 | Low byte |
| data_hi_o | output | 8 | High byte |

## Verification
The bench targets the cycles where a read strobe and a conversion pulse coincide:
- If the lock updated too early, a low-byte read would return a torn value.
- If a high-byte read with a conversion dropped the new result, the bench would see stale data after release.
- If the pending slot kept the first result instead of the last, the bench would see an old result after release.

Other directed checks cover:
- a high-byte-only read that leaves the lock set, which would freeze later results;
- packing that does not follow a change of the select bit.

A long random run compares both bytes against a behavioural model on every cycle.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int unsigned RES_W  = 10;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/adc_res_lock.sv
module adc_res_lock #(
  parameter int unsigned RES_W = adc_res_pkg::RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_data_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [RES_W-1:0] res_o
);
  logic             lock_q, pend_vld_q;
  logic [RES_W-1:0] res_q, pend_q;
  logic             hold;

  // locked after this cycle unless the high byte is read now
  assign hold = (lock_q | rd_lo_i) & ~rd_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      res_q      <= '0;
      pend_q     <= '0;
    end else if (hold) begin
      lock_q <= 1'b1;
      if (conv_done_i) begin
        pend_q     <= conv_data_i;
        pend_vld_q <= 1'b1;
      end
    end else begin
      lock_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      if (conv_done_i)     res_q <= conv_data_i;
      else if (pend_vld_q) res_q <= pend_q;
    end
  end

  assign res_o = res_q;

  p_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !rd_hi_i) |=> $stable(res_o));
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hi_i |=> !lock_q);
  p_lo_locks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i) |=> lock_q);
  p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !rd_lo_i && conv_done_i) |=> res_o == $past(conv_data_i));
  p_pend_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && rd_hi_i && !conv_done_i && pend_vld_q) |=> res_o == $past(pend_q));
  p_same_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && !rd_hi_i && conv_done_i) |=> (pend_vld_q && pend_q == $past(conv_data_i)));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
  parameter int unsigned RES_W  = adc_res_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_res_pkg::BYTE_W
) (
  input  logic [RES_W-1:0]  res_i,
  input  logic              left_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int unsigned WORD_W = 2 * BYTE_W;
  localparam int unsigned PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word;

  generate
    if (PAD_W == 0) begin : g_full
      assign word = res_i;
    end else begin : g_pad
      assign word = left_i ? {res_i, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, res_i};
    end
  endgenerate

  assign hi_o = word[WORD_W-1:BYTE_W];
  assign lo_o = word[BYTE_W-1:0];
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int unsigned RES_W  = adc_res_pkg::RES_W,
  parameter int unsigned BYTE_W = adc_res_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  input  logic              align_left_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] data_lo_o,
  output logic [BYTE_W-1:0] data_hi_o
);
  localparam int unsigned PAD_W = 2 * BYTE_W - RES_W;

  logic [RES_W-1:0] res;

  adc_res_lock #(.RES_W(RES_W)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .rd_lo_i     (rd_lo_i),
    .rd_hi_i     (rd_hi_i),
    .res_o       (res)
  );

  adc_res_align #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_align (
    .res_i  (res),
    .left_i (align_left_i),
    .hi_o   (data_hi_o),
    .lo_o   (data_lo_o)
  );

  p_right_pad_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_left_i |-> (data_hi_o >> (RES_W - BYTE_W)) == '0);
  p_left_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_left_i |-> (data_lo_o << (BYTE_W - PAD_W)) == '0);
  p_realign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(res) && $stable(align_left_i)) |-> ($stable(data_hi_o) && $stable(data_lo_o)));
endmodule

// File: tb/sim_adc_result_reg.sv
`timescale 1ns/1ps
module sim_adc_result_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv = 1'b0, align = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [9:0] data = '0;
  logic [7:0] lo, hi;

  int n_cmp = 0, n_bad = 0;
  int m_res = 0, m_pend = 0;
  bit m_lock = 0, m_pv = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  adc_result_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .conv_done_i(conv), .conv_data_i(data),
    .align_left_i(align), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .data_lo_o(lo), .data_hi_o(hi)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_res = 0; m_pend = 0; m_lock = 0; m_pv = 0;
    end else if ((m_lock || rd_lo) && !rd_hi) begin
      m_lock = 1;
      if (conv) begin m_pend = int'(data); m_pv = 1; end
    end else begin
      m_lock = 0;
      if (conv) m_res = int'(data);
      else if (m_pv) m_res = m_pend;
      m_pv = 0;
    end
  end

  function automatic int exp_hi(int v, bit l);
    return l ? (v >> 2) & 255 : (v >> 8) & 3;
  endfunction
  function automatic int exp_lo(int v, bit l);
    return l ? (v & 3) << 6 : v & 255;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (int'(hi) != exp_hi(m_res, align) || int'(lo) != exp_lo(m_res, align)) begin
        n_bad++;
        $display("FAIL %s model: hi=%02h lo=%02h expected hi=%02h lo=%02h",
                 tag, hi, lo, exp_hi(m_res, align), exp_lo(m_res, align));
      end
    end
  end

  task automatic drv(bit c, int d, bit l, bit h);
    @(posedge clk); #1;
    conv = c; data = d[9:0]; rd_lo = l; rd_hi = h;
  endtask
  task automatic idle();
    drv(0, 0, 0, 0);
  endtask
  task automatic chk(string t, int eh, int el);
    @(negedge clk); #0.1;
    n_cmp++;
    if (int'(hi) != eh || int'(lo) != el) begin
      n_bad++;
      $display("FAIL %s: hi=%02h lo=%02h expected hi=%02h lo=%02h", t, hi, lo, eh, el);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1; chk("R1 in reset", 0, 0);
    #9 rst_n = 1'b1;
    chk("R1", 0, 0);
    tag = "R4";
    drv(1, 'h2A5, 0, 0); idle(); chk("R4 R2", 'h02, 'hA5);
    tag = "R3"; #0.5 align = 1'b1; chk("R3 R8", 'hA9, 'h40);
    drv(1, 'h3FF, 0, 0); idle(); chk("R3 full", 'hFF, 'hC0);
    drv(1, 'h2A5, 0, 0); #0.5 align = 1'b0; idle(); chk("R8", 'h02, 'hA5);
    tag = "R5";
    drv(0, 0, 1, 0); drv(1, 'h155, 0, 0); idle(); chk("R5", 'h02, 'hA5);
    tag = "R7";
    drv(1, 'h0F0, 0, 0); drv(0, 0, 0, 1); chk("R7 hi read cycle", 'h02, 'hA5);
    idle(); chk("R7 newest pending", 'h00, 'hF0);
    tag = "R6";
    drv(0, 0, 0, 1); idle(); drv(1, 'h3FF, 0, 0); idle(); chk("R6 hi-only read", 'h03, 'hFF);
    tag = "R9";
    drv(1, 'h001, 1, 0); chk("R9 same cycle", 'h03, 'hFF);
    idle(); chk("R9 held", 'h03, 'hFF);
    drv(0, 0, 0, 1); idle(); chk("R9 released", 'h00, 'h01);
    tag = "R10";
    drv(0, 0, 1, 0); drv(1, 'h100, 0, 0); drv(1, 'h222, 0, 1); chk("R10 same cycle", 'h00, 'h01);
    idle(); chk("R10 newest commits", 'h02, 'h22);
    drv(0, 0, 1, 1); drv(1, 'h3C3, 0, 0); idle(); chk("R10 lo+hi together", 'h03, 'hC3);
    tag = "R7 random";
    for (int i = 0; i < 3000; i++) begin
      drv($urandom_range(0, 1), int'($urandom_range(0, 1023)),
          $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
      if ($urandom_range(0, 15) == 0) #0.5 align = ~align;
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule